// File: doc/BRIEF.md
# Clock-Master Serial Receiver with Double Buffering

This block receives synchronous serial data while acting as clock master. It divides the system clock down to a shift clock, drives that clock out on `sclk_o`, and samples the serial input `sdi` on each rising edge of that clock. Each frame holds a fixed number of bits (eight by default), received least significant bit first, into a shift register.

A mode input selects one of two buffering schemes. With single buffering, the shift register is the only store. After one frame the clock stays idle until the CPU reads the byte. With double buffering, a finished frame moves into a holding register, and the shift register goes straight on to the next frame. If the holding register is still unread when the next frame finishes, the shift clock freezes high. A read of the holding register then brings in the waiting frame and restarts the clock.

The CPU side has four signals: a one-cycle read strobe, the read data, a buffer-full flag and a one-cycle receive interrupt. The shift-clock half-period is a run-time divider value counted in system clock cycles.

Top module: `srx_master`

## Requirements
- R1: After reset `sclk_o` is 1, `buf_full` is 0 and `rx_irq` is 0. While `rx_en` is 0 and no frame is under way, `sclk_o` makes no edge.
- R2: Each frame takes exactly 8 rising edges of `sclk_o`. Completion of a frame gives a `rx_irq` pulse that lasts exactly one system clock cycle.
- R3: Bits are taken LSB first: the first bit sampled lands in `rd_data[0]` and the eighth in `rd_data[7]`.
- R4: `sdi` is sampled on the rising edge of `sclk_o`. Each half-period of `sclk_o`, for example from a falling edge to the next rising edge, lasts `div_val` system clock cycles (`div_val` >= 1). Between frames `sclk_o` rests at 1.
- R5: Single buffering (`dbl_en` = 0): a completed frame sets `buf_full` and `rd_data` shows the byte. No further `sclk_o` edge occurs until a `rd_stb` pulse. That pulse clears `buf_full` and, if `rx_en` is 1, starts the next frame.
- R6: Double buffering (`dbl_en` = 1): a frame that completes while the holding register is empty (or is being read in the same cycle) moves into it. This sets `buf_full` to 1, raises `rx_irq`, and the next frame is clocked in without a pause.
- R7: Double buffering: if a frame completes while the holding register is still full and unread, no `rx_irq` is raised and `sclk_o` stays at 1.
- R8: In that stalled state, a `rd_stb` pulse moves the waiting frame into the holding register. On the next cycle `rx_irq` is 1 and `rd_data` shows the new byte, `buf_full` stays 1, and the shift clock resumes if `rx_en` is 1.
- R9: Double buffering: a `rd_stb` pulse while the holding register is full and no frame is waiting clears `buf_full` and raises no `rx_irq`.
- R10: Clearing `rx_en` in the middle of a frame lets that frame finish and be delivered normally. After that, `sclk_o` stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; starts clocking when set |
| dbl_en | input | 1 | 1 selects double buffering, 0 single buffering |
| div_val | input | DIV_W | Shift-clock half-period in system clock cycles |
| rd_stb | input | 1 | One-cycle CPU read strobe |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Shift clock out, idles high |
| rd_data | output | FRAME_BITS | Received byte visible to the CPU |
| buf_full | output | 1 | A received byte awaits reading |
| rx_irq | output | 1 | One-cycle receive interrupt |

## Verification
The assertions assume three things about the inputs. `div_val` is at least 1 and is held steady while the shift clock runs. `dbl_en` changes only while the receiver is idle and empty. `rd_stb` is a single-cycle pulse. The stimulus meets these conditions in every test. It changes `div_val` and the mode only after `rx_en` is cleared and the last byte has been read. It drives `sdi` only just after a falling edge of `sclk_o`, so the value is stable for a whole half-period before the rising edge that samples it. It issues each read as a single strobe between two falling system clock edges.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic {
      BUF_SINGLE = 1'b0,
      BUF_DOUBLE = 1'b1
   } buf_mode_e;
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   output logic             sclk,
   output logic             sample
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] hcnt;
   logic             tick;

   assign tick   = (hcnt == div_val - ONE);
   assign sample = run && tick && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         sclk <= 1'b1;
      end else if (!run) begin
         hcnt <= '0;
         sclk <= 1'b1;
      end else if (tick) begin
         hcnt <= '0;
         sclk <= ~sclk;
      end else begin
         hcnt <= hcnt + ONE;
      end
   end

   // R4: half-period counter never passes the programmed divider
   assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && div_val != '0) |-> (hcnt < div_val));
   // R4: input assumption, divider is non-zero while clocking
   assert_div_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (div_val != '0));
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
   parameter int FRAME_BITS = 8,
   parameter int CNT_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sample,
   input  logic                  sdi,
   output logic [FRAME_BITS-1:0] word,
   output logic [FRAME_BITS-1:0] word_next,
   output logic [CNT_W-1:0]      nbits,
   output logic                  done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   // LSB first: new bit enters at the top and moves down toward bit 0
   assign word_next = {sdi, word[FRAME_BITS-1:1]};
   assign done      = sample && (nbits == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         nbits <= '0;
      end else if (sample) begin
         word  <= word_next;
         nbits <= done ? '0 : nbits + STEP;
      end
   end

   // R2: the bit count moves only on a sampling edge
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> $stable(nbits));
endmodule

// File: rtl/srx_bufctl.sv
module srx_bufctl
   import srx_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   parameter int CNT_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_en,
   input  logic                  dbl_en,
   input  logic                  rd_stb,
   input  logic                  done,
   input  logic                  sclk,
   input  logic [CNT_W-1:0]      nbits,
   input  logic [FRAME_BITS-1:0] word,
   input  logic [FRAME_BITS-1:0] word_next,
   output logic                  run,
   output logic                  irq,
   output logic                  buf_full,
   output logic [FRAME_BITS-1:0] rd_data
);
   buf_mode_e             mode;
   logic                  sh_full;
   logic                  hold_full;
   logic [FRAME_BITS-1:0] hold;
   logic                  hold_free;
   logic                  busy;

   assign mode      = buf_mode_e'(dbl_en);
   assign hold_free = !hold_full || rd_stb;
   assign busy      = (nbits != '0) || !sclk;
   assign run       = !sh_full && (rx_en || busy);
   assign rd_data   = (mode == BUF_DOUBLE) ? hold : word;
   assign buf_full  = (mode == BUF_DOUBLE) ? hold_full : sh_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_full   <= 1'b0;
         hold_full <= 1'b0;
         hold      <= '0;
         irq       <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (mode == BUF_SINGLE) begin
            hold_full <= 1'b0;
            if (done) begin
               sh_full <= 1'b1;
               irq     <= 1'b1;
            end else if (rd_stb && sh_full) begin
               sh_full <= 1'b0;
            end
         end else begin
            if (done) begin
               if (hold_free) begin
                  hold      <= word_next;
                  hold_full <= 1'b1;
                  irq       <= 1'b1;
               end else begin
                  sh_full <= 1'b1;
               end
            end else if (rd_stb && sh_full) begin
               hold    <= word;
               sh_full <= 1'b0;
               irq     <= 1'b1;
            end else if (rd_stb && hold_full) begin
               hold_full <= 1'b0;
            end
         end
      end
   end

   // R2: interrupt lasts a single cycle
   assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R7: a waiting frame keeps the shift clock parked high
   assert_stall_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sh_full |-> sclk);
   // R7: no interrupt when a frame lands on a full, unread holding register
   assert_no_irq_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode == BUF_DOUBLE && hold_full && !rd_stb) |=> !irq);
   // R9: the holding flag drops only after a read
   assert_flag_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUF_DOUBLE && $fell(hold_full)) |-> $past(rd_stb));
endmodule

// File: rtl/srx_master.sv
module srx_master #(
   parameter int FRAME_BITS = 8,
   parameter int DIV_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_en,
   input  logic                  dbl_en,
   input  logic [DIV_W-1:0]      div_val,
   input  logic                  rd_stb,
   input  logic                  sdi,
   output logic                  sclk_o,
   output logic [FRAME_BITS-1:0] rd_data,
   output logic                  buf_full,
   output logic                  rx_irq
);
   localparam int CNT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("FRAME_BITS must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic                  run;
   logic                  sample;
   logic                  done;
   logic [CNT_W-1:0]      nbits;
   logic [FRAME_BITS-1:0] word;
   logic [FRAME_BITS-1:0] word_next;

   srx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .div_val (div_val),
      .sclk    (sclk_o),
      .sample  (sample)
   );

   srx_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (sample),
      .sdi       (sdi),
      .word      (word),
      .word_next (word_next),
      .nbits     (nbits),
      .done      (done)
   );

   srx_bufctl #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_bufctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .dbl_en    (dbl_en),
      .rd_stb    (rd_stb),
      .done      (done),
      .sclk      (sclk_o),
      .nbits     (nbits),
      .word      (word),
      .word_next (word_next),
      .run       (run),
      .irq       (rx_irq),
      .buf_full  (buf_full),
      .rd_data   (rd_data)
   );

   // R10: with enable low at a frame boundary the clock stays parked
   assert_stop_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && nbits == '0 && sclk_o && !done) |=> sclk_o);
endmodule

// File: tb/srx_master_test.sv
`timescale 1ns/1ps
module srx_master_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       dbl_en = 1'b0;
   logic [7:0] div_val = 8'd1;
   logic       rd_stb = 1'b0;
   logic       sdi = 1'b0;
   logic       sclk_o;
   logic [7:0] rd_data;
   logic       buf_full;
   logic       rx_irq;

   int checks = 0;
   int errors = 0;
   int rises = 0;
   int irq_cnt = 0;
   int half_ns = 0;
   realtime t_fall = 0;
   logic [7:0] tx_q [32];
   int wr_p = 0;
   int rd_p = 0;
   int bit_i = 0;
   logic [7:0] cur = 8'h00;

   always #4 clk = ~clk;

   srx_master uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_en(dbl_en),
      .div_val(div_val), .rd_stb(rd_stb), .sdi(sdi), .sclk_o(sclk_o),
      .rd_data(rd_data), .buf_full(buf_full), .rx_irq(rx_irq)
   );

   // serial source: next bit presented just after each falling edge
   always @(negedge sclk_o) begin
      t_fall = $realtime;
      if (bit_i == 0) begin
         cur = tx_q[rd_p % 32];
         rd_p = rd_p + 1;
      end
      sdi = cur[bit_i];
      bit_i = (bit_i + 1) % 8;
   end

   always @(posedge sclk_o) begin
      rises = rises + 1;
      half_ns = int'($realtime - t_fall);
   end

   always @(negedge clk) if (rx_irq) irq_cnt = irq_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      tx_q[wr_p % 32] = b;
      wr_p = wr_p + 1;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic read_byte();
      @(negedge clk) rd_stb = 1'b1;
      @(negedge clk) rd_stb = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      bit seen = 1'b0;
      for (int k = 0; k < 8000; k++) begin
         @(negedge clk);
         if (rx_irq) begin
            seen = 1'b1;
            break;
         end
      end
      chk({req, " irq seen"}, int'(seen), 1);
      @(negedge clk);
      chk("R2 irq one cycle", int'(rx_irq), 0);
   endtask

   task automatic wait_rises(input int base, input int n);
      for (int k = 0; k < 8000; k++) begin
         if (rises - base >= n) break;
         @(negedge clk);
      end
   endtask

   localparam logic [15:0] VEC [4] = '{16'h01A5, 16'h023C, 16'h0301, 16'h0580};

   initial begin
      int r0;
      int i0;
      idle(3);
      // R1 reset state
      chk("R1 sclk idle", int'(sclk_o), 1);
      chk("R1 buf_full", int'(buf_full), 0);
      chk("R1 irq", int'(rx_irq), 0);
      rst_n = 1'b1;
      r0 = rises;
      idle(40);
      chk("R1 no edges disabled", rises - r0, 0);

      // table walk: single buffering at several dividers
      for (int v = 0; v < 4; v++) begin
         div_val = VEC[v][15:8];
         push(VEC[v][7:0]);
         r0 = rises;
         @(negedge clk) rx_en = 1'b1;
         wait_irq("R2");
         rx_en = 1'b0;
         chk("R3 data LSB first", int'(rd_data), int'(VEC[v][7:0]));
         chk("R2 edges per frame", rises - r0, 8);
         chk("R4 half period ns", half_ns, int'(VEC[v][15:8]) * 8);
         chk("R5 flag set", int'(buf_full), 1);
         chk("R4 idle high", int'(sclk_o), 1);
         read_byte();
         chk("R5 flag cleared", int'(buf_full), 0);
      end

      // R5 clock waits for read, then next frame
      div_val = 8'd1;
      push(8'h11); push(8'h22);
      r0 = rises;
      @(negedge clk) rx_en = 1'b1;
      wait_irq("R5");
      chk("R5 first byte", int'(rd_data), 8'h11);
      idle(40);
      chk("R5 no edges before read", rises - r0, 8);
      read_byte();
      wait_irq("R5");
      rx_en = 1'b0;
      chk("R5 second byte", int'(rd_data), 8'h22);
      chk("R5 edges two frames", rises - r0, 16);
      read_byte();

      // R10 enable cleared mid-frame
      div_val = 8'd3;
      push(8'h69);
      r0 = rises;
      @(negedge clk) rx_en = 1'b1;
      wait_rises(r0, 3);
      rx_en = 1'b0;
      wait_irq("R10");
      chk("R10 byte delivered", int'(rd_data), 8'h69);
      idle(50);
      chk("R10 stopped after frame", rises - r0, 8);
      read_byte();
      idle(30);
      chk("R10 stays stopped", rises - r0, 8);

      // double buffering
      dbl_en = 1'b1;
      div_val = 8'd2;
      idle(2);
      push(8'h5A); push(8'hC3); push(8'h96);
      r0 = rises;
      @(negedge clk) rx_en = 1'b1;
      wait_irq("R6");
      chk("R6 hold byte", int'(rd_data), 8'h5A);
      chk("R6 flag set", int'(buf_full), 1);
      wait_rises(r0, 16);
      chk("R6 kept shifting", rises - r0, 16);
      i0 = irq_cnt;
      idle(60);
      chk("R7 stalled edges", rises - r0, 16);
      chk("R7 sclk high", int'(sclk_o), 1);
      chk("R7 no irq", irq_cnt - i0, 0);
      chk("R7 hold unchanged", int'(rd_data), 8'h5A);
      read_byte();
      chk("R8 irq after read", int'(rx_irq), 1);
      chk("R8 moved byte", int'(rd_data), 8'hC3);
      chk("R8 flag stays", int'(buf_full), 1);
      wait_rises(r0, 24);
      chk("R8 clock resumed", rises - r0, 24);
      idle(40);
      rx_en = 1'b0;
      chk("R7 second stall", rises - r0, 24);
      read_byte();
      chk("R8 irq second", int'(rx_irq), 1);
      chk("R8 third byte", int'(rd_data), 8'h96);
      idle(40);
      chk("R10 no restart when disabled", rises - r0, 24);
      i0 = irq_cnt;
      read_byte();
      idle(2);
      chk("R9 flag cleared", int'(buf_full), 0);
      chk("R9 no irq", irq_cnt - i0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule